// File: doc/BRIEF.md
# UART Transmit Queue with Empty-Interrupt Holdoff

This block is the byte queue that sits between the CPU write path and the transmit shift register of a serial port. It holds up to DEPTH bytes, 16 by default. The CPU offers a byte with `wr_en`, and `wr_accept` reports in the same cycle whether the byte was taken. The shifter pulls the oldest byte with `pop_req` and reads it from `pop_data`. Fill level is reported on `full`, `empty` and `count`.

The block raises a transmitter-empty interrupt whenever the queue is empty and the interrupt is enabled. A holdoff rule stops the interrupt from re-firing while software is still refilling the queue. Suppose a byte is written into an empty queue and the shifter drains it before a second byte arrives. The interrupt then stays low until HOLD_CHARS pulses of `char_tick` have been seen after the queue went empty. HOLD_CHARS is a count of character times, and `char_tick` comes from an external baud-timing source. Once the queue has held two bytes at the same moment, the holdoff is disarmed, and the next time the queue empties the interrupt fires at once. A write into an empty queue, including one made during a holdoff, arms the holdoff again with its character count reset to zero.

Top module: `uart_txq`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, `full` is 0, and `irq` equals `irq_en`.
- R2: Bytes leave on `pop_data` in the order they were accepted. `pop_data` always shows the oldest stored byte.
- R3: The queue stores at most DEPTH bytes, and `full` is 1 exactly when `count` equals DEPTH. A write offered while full with no pop gives `wr_accept` = 0 and leaves the contents unchanged.
- R4: A write offered while full, in the same cycle as a pop, is accepted. `count` stays at DEPTH and the new byte is placed behind the others.
- R5: An accepted write and a pop in the same cycle leave `count` unchanged, and both bytes are handled correctly.
- R6: A pop request while empty has no effect: `count` stays 0.
- R7: `irq` is 1 only when `irq_en` is 1, the queue is empty, and no holdoff is pending. Clearing `irq_en` drops `irq` in the same cycle.
- R8: An accepted write drives `irq` to 0 from the next cycle.
- R9: Suppose a byte is written into an empty queue and is drained before a second byte is queued alongside it. Then `irq` stays 0 after the queue empties until HOLD_CHARS `char_tick` pulses have been sampled. It rises in the cycle after the clock edge that samples the last of those pulses.
- R10: After the queue has held two bytes at once, the pop that empties it makes `irq` rise in the next cycle, with no holdoff.
- R11: A write during a pending holdoff cancels it. When the queue next empties, the holdoff count starts again from zero.
- R12: `char_tick` has no effect on `irq` or `count` when no holdoff is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | CPU offers a byte this cycle |
| wr_data | input | WIDTH | Byte offered by the CPU |
| wr_accept | output | 1 | Offered byte is stored at the coming edge |
| pop_req | input | 1 | Shifter takes the oldest byte |
| pop_data | output | WIDTH | Oldest stored byte |
| char_tick | input | 1 | One-cycle pulse per serial character time |
| irq_en | input | 1 | Transmitter-empty interrupt enable |
| irq | output | 1 | Transmitter-empty interrupt |
| full | output | 1 | Queue holds DEPTH bytes |
| empty | output | 1 | Queue holds no bytes |
| count | output | $clog2(DEPTH+1) | Number of stored bytes |

## Verification
The hardest situation to reach is a holdoff that restarts after it has been partly counted down. The queue must go empty after a single-byte episode, and one `char_tick` must be sampled. Then a byte must be written and drained again before the remaining ticks arrive. The bench builds this from cycle-exact write, pop and tick pulses, with HOLD_CHARS set to 2. A timer that failed to restart would then raise the interrupt one tick early. The full-queue write that coincides with a pop is reached by filling all 16 slots first and then offering a write and a pop in the same cycle.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Holdoff tracker states for the transmitter-empty interrupt.
  //   HS_READY : no holdoff armed; an empty queue interrupts at once
  //   HS_ARMED : one byte loaded into an empty queue, second not yet seen
  //   HS_WAIT  : queue drained while armed; counting character times
  typedef enum logic [1:0] {
    HS_READY = 2'd0,
    HS_ARMED = 2'd1,
    HS_WAIT  = 2'd2
  } hold_state_e;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] slot_q [DEPTH];

  // One register bank per entry, each with its own write enable.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (waddr == AW'(gi));

    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[gi] <= wdata;
      end
    end
  end

  assign rdata = slot_q[raddr];

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          pop_req,
  output logic          wr_acc,
  output logic          pop_fire,
  output logic          last_pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_n;
  logic [AW-1:0] rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] count_q, count_n;
  logic          cnt_en;

  assign empty    = (count_q == '0);
  assign full     = (count_q == FULL_CNT);
  assign pop_fire = pop_req && !empty;
  // A pop frees a slot in the same cycle, so a full queue still takes the write.
  assign wr_acc   = wr_en && (!full || pop_fire);
  assign last_pop = pop_fire && !wr_acc && (count_q == CW'(1));

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    if (wr_acc) begin
      wr_ptr_n = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_fire) begin
      rd_ptr_n = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  always_comb begin
    cnt_en  = 1'b0;
    count_n = count_q;
    unique case ({wr_acc, pop_fire})
      2'b10: begin
        cnt_en  = 1'b1;
        count_n = count_q + 1'b1;
      end
      2'b01: begin
        cnt_en  = 1'b1;
        count_n = count_q - 1'b1;
      end
      default: begin
        cnt_en  = 1'b0;
        count_n = count_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_acc) begin
        wr_ptr_q <= wr_ptr_n;
      end
      if (pop_fire) begin
        rd_ptr_q <= rd_ptr_n;
      end
      if (cnt_en) begin
        count_q <= count_n;
      end
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
  assign count  = count_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);

  // R3
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req) |=> (count_q == FULL_CNT));

  // R5
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && pop_fire) |=> $stable(count_q));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !wr_en) |=> (count_q == '0));

endmodule

// File: rtl/txq_irq.sv
module txq_irq
  import txq_pkg::*;
#(
  parameter int HOLD_CHARS = 1,
  localparam int HW = $clog2(HOLD_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_acc,
  input  logic pop_fire,
  input  logic last_pop,
  input  logic empty,
  input  logic char_tick,
  input  logic irq_en,
  output logic irq_o
);

  localparam logic [HW-1:0] TICK_LAST = HW'(HOLD_CHARS - 1);

  hold_state_e   state_q, state_n;
  logic [HW-1:0] tcnt_q, tcnt_n;
  logic          tcnt_en;

  always_comb begin
    state_n = state_q;
    tcnt_n  = tcnt_q;
    tcnt_en = 1'b0;
    unique case (state_q)
      HS_READY: begin
        // First byte into an empty queue arms the holdoff.
        if (wr_acc && empty) begin
          state_n = HS_ARMED;
        end
      end
      HS_ARMED: begin
        // Armed implies exactly one byte stored.
        if (wr_acc && !pop_fire) begin
          state_n = HS_READY;
        end else if (pop_fire && !wr_acc) begin
          state_n = HS_WAIT;
          tcnt_en = 1'b1;
          tcnt_n  = '0;
        end
      end
      HS_WAIT: begin
        if (wr_acc) begin
          state_n = HS_ARMED;
        end else if (char_tick) begin
          if (tcnt_q == TICK_LAST) begin
            state_n = HS_READY;
          end else begin
            tcnt_en = 1'b1;
            tcnt_n  = tcnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_n = HS_READY;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_READY;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      if (tcnt_en) begin
        tcnt_q <= tcnt_n;
      end
    end
  end

  assign irq_o = irq_en && empty && (state_q != HS_WAIT);

  // R8
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !irq_o);

  // R9
  hold_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_ARMED && pop_fire && !wr_acc) |=> !irq_o);

  // R10
  fast_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_READY && last_pop && irq_en) |=> (irq_o || !irq_en));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_WAIT && wr_acc) |=> (state_q == HS_ARMED));

endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DEPTH      = 16,
  parameter int WIDTH      = 8,
  parameter int HOLD_CHARS = 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_accept,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  input  logic             char_tick,
  input  logic             irq_en,
  output logic             irq,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);

  logic          wr_acc;
  logic          pop_fire;
  logic          last_pop;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          q_empty;

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .pop_req  (pop_req),
    .wr_acc   (wr_acc),
    .pop_fire (pop_fire),
    .last_pop (last_pop),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (count),
    .full     (full),
    .empty    (q_empty)
  );

  txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .we    (wr_acc),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (pop_data)
  );

  txq_irq #(.HOLD_CHARS(HOLD_CHARS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_acc    (wr_acc),
    .pop_fire  (pop_fire),
    .last_pop  (last_pop),
    .empty     (q_empty),
    .char_tick (char_tick),
    .irq_en    (irq_en),
    .irq_o     (irq)
  );

  assign wr_accept = wr_acc;
  assign empty     = q_empty;

endmodule

// File: tb/uart_txq_bench.sv
module uart_txq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int HOLD       = 2;
  localparam int CW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, pop_req, char_tick, irq_en;
  logic [7:0]    wr_data;
  logic          wr_accept, irq, full, empty;
  logic [7:0]    pop_data;
  logic [CW-1:0] count;

  int   total = 0;
  int   bad   = 0;
  logic acc_s;
  logic [7:0] pd_s;

  uart_txq #(.DEPTH(DEPTH), .WIDTH(8), .HOLD_CHARS(HOLD)) u_uart_txq (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .wr_accept (wr_accept), .pop_req (pop_req), .pop_data (pop_data),
    .char_tick (char_tick), .irq_en (irq_en), .irq (irq),
    .full (full), .empty (empty), .count (count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus; starts and ends just after a rising edge.
  task automatic cyc(input logic wr, input logic [7:0] d, input logic pop, input logic tk);
    wr_en = wr; wr_data = d; pop_req = pop; char_tick = tk;
    #(CLK_PERIOD / 4);
    acc_s = wr_accept;
    pd_s  = pop_data;
    @(posedge clk);
    #1;
    wr_en = 1'b0; pop_req = 1'b0; char_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", int'(count), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 irq", int'(irq), 1);
  endtask

  task automatic t_order();
    cyc(1, 8'hA1, 0, 0);
    chk("R8 irq after write", int'(irq), 0);
    cyc(1, 8'hB2, 0, 0);
    cyc(1, 8'hC3, 0, 0);
    chk("R2 head", int'(pop_data), 'hA1);
    cyc(0, 0, 1, 0); chk("R2 first", int'(pd_s), 'hA1);
    cyc(0, 0, 1, 0); chk("R2 second", int'(pd_s), 'hB2);
    cyc(0, 0, 1, 0); chk("R2 third", int'(pd_s), 'hC3);
    chk("R10 immediate irq", int'(irq), 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h10 + i), 0, 0);
    chk("R3 full", int'(full), 1);
    chk("R3 count", int'(count), DEPTH);
    cyc(1, 8'hEE, 0, 0);
    chk("R3 reject", int'(acc_s), 0);
    chk("R3 count kept", int'(count), DEPTH);
    cyc(1, 8'hEF, 1, 0);
    chk("R4 accept", int'(acc_s), 1);
    chk("R4 popped", int'(pd_s), 'h10);
    chk("R4 count", int'(count), DEPTH);
    for (int i = 1; i < DEPTH; i++) begin
      cyc(0, 0, 1, 0);
      chk("R3 drain", int'(pd_s), 'h10 + i);
    end
    cyc(0, 0, 1, 0);
    chk("R4 tail byte", int'(pd_s), 'hEF);
    chk("R10 irq after drain", int'(irq), 1);
    cyc(0, 0, 1, 0);
    chk("R6 pop empty", int'(count), 0);
    chk("R6 empty kept", int'(empty), 1);
  endtask

  task automatic t_mixed();
    cyc(1, 8'h55, 0, 0);
    cyc(1, 8'h66, 1, 0);
    chk("R5 accept", int'(acc_s), 1);
    chk("R5 popped", int'(pd_s), 'h55);
    chk("R5 count", int'(count), 1);
    cyc(0, 0, 1, 0);
    chk("R5 second byte", int'(pd_s), 'h66);
    chk("R9 held after mixed", int'(irq), 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk("R9 released", int'(irq), 1);
  endtask

  task automatic t_holdoff();
    cyc(1, 8'h77, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R9 held", int'(irq), 0);
    repeat (3) cyc(0, 0, 0, 0);
    chk("R9 held idle", int'(irq), 0);
    cyc(0, 0, 0, 1);
    chk("R9 one tick", int'(irq), 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R9 after ticks", int'(irq), 1);
    cyc(0, 0, 0, 1);
    chk("R12 tick irq", int'(irq), 1);
    chk("R12 tick count", int'(count), 0);
  endtask

  task automatic t_restart();
    cyc(1, 8'h91, 0, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 1);
    chk("R11 partial", int'(irq), 0);
    cyc(1, 8'h92, 0, 0);
    chk("R8 write in hold", int'(irq), 0);
    cyc(0, 0, 1, 0);
    chk("R11 data", int'(pd_s), 'h92);
    cyc(0, 0, 0, 1);
    chk("R11 restarted", int'(irq), 0);
    cyc(0, 0, 0, 1);
    chk("R11 released", int'(irq), 1);
  endtask

  task automatic t_enable();
    irq_en = 1'b0;
    #1;
    chk("R7 disable same cycle", int'(irq), 0);
    cyc(0, 0, 0, 0);
    chk("R7 disabled", int'(irq), 0);
    irq_en = 1'b1;
    #1;
    chk("R7 enable", int'(irq), 1);
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; pop_req = 1'b0; char_tick = 1'b0;
    wr_data = '0; irq_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_order();
    t_full();
    t_mixed();
    t_holdoff();
    t_restart();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule